// File: doc/BRIEF.md
# Prescaled Compare Timer

This block is a free-running up counter with several compare channels, meant to serve as a time base for software supervision. A programmable prescaler divides the system clock before it reaches the counter. Each compare channel holds a target value. When the counter steps onto that value and the channel is enabled, the channel raises a sticky flag that drives its own interrupt line. While a debug-halt input is held high, the counter and the prescaler phase stay where they are.

Software reaches the block through a simple register bus. Writes take effect at the clock edge where `bus_we` is sampled high. Reads are combinational on `bus_rdata` for the address currently presented.

The register addresses are:

- 0: control. Bit 0 is the run bit. Bits [15:8] hold the prescale value N.
- 1: counter value.
- 2: flags. The low four bits hold the channel flags and are cleared by writing ones.
- 3: channel enables. The low four bits enable channels 0 to 3.
- 4 to 7: compare values for channels 0 to 3.

Top module: `tmr_compare_unit`

## Requirements
- R1: After reset, every register reads zero and all interrupt outputs are low. This covers the control, counter, flags, enables and compare values.
- R2: With the run bit (control bit 0) set and prescale N (control bits [15:8]), the counter advances by exactly one every N+1 clock cycles. N = 0 counts every cycle.
- R3: While the run bit is clear, the counter holds its value.
- R4: A write to address 1 loads the counter with the written value and restarts the prescaler phase. The first advance after the load comes N+1 edges after the write edge.
- R5: The counter wraps from all ones to zero and keeps counting.
- R6: While `debug_halt` is high, neither the counter nor the prescaler phase changes, except by a counter write.
- R7: An enabled channel sets its flag on the same clock edge at which the counter advances onto its compare value. Interrupt line k follows flag k.
- R8: A disabled channel never sets its flag. Loading the counter directly with a compare value does not set a flag.
- R9: Flags stay set until software writes a one to their bit at address 2. Written zeros have no effect. If a set and a clear fall on the same edge, the set wins.
- R10: Every register reads back on `bus_rdata` in the same cycle its address is presented, with unused bits zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| debug_halt | input | 1 | Freezes counter and prescaler while high |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W (3) | Register address |
| bus_wdata | input | CNT_W (32) | Write data |
| bus_rdata | output | CNT_W (32) | Combinational read data for `bus_addr` |
| irq | output | NCH (4) | Per-channel interrupt, one line per compare channel |

## Verification
After a counter write at edge E, the counter holds the written value plus floor(W/(N+1)) once W further edges have passed. The bench therefore counts edges from the write edge and samples at the following falling edge. A compare flag and its interrupt are due at the same edge that brings the counter onto the compare value, so checks bracket that edge: low one edge early, high exactly on it. Flag clears and the set-beats-clear case are sampled on the falling edge right after the write edge. Register readback is sampled one time step after the address is driven, with no clock edge in between.

// File: rtl/tmr_cmp_pkg.sv
package tmr_cmp_pkg;
    localparam int unsigned REG_CTRL     = 0;
    localparam int unsigned REG_COUNT    = 1;
    localparam int unsigned REG_FLAGS    = 2;
    localparam int unsigned REG_CHEN     = 3;
    localparam int unsigned REG_CMP_BASE = 4;
    localparam int unsigned CTRL_RUN_BIT = 0;
    localparam int unsigned CTRL_DIV_LSB = 8;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             halt,
    input  logic             restart,
    input  logic [PRE_W-1:0] div,
    output logic             tick
);
    typedef struct packed {
        logic [PRE_W-1:0] phase;
    } pre_st_t;

    pre_st_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        tick = 1'b0;
        if (restart) begin
            s_d.phase = '0;
        end else if (run && !halt) begin
            if (s_q.phase >= div) begin
                tick      = 1'b1;
                s_d.phase = '0;
            end else begin
                s_d.phase = s_q.phase + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R4: a counter write restarts the phase
    assert_phase_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (s_q.phase == '0));

    // R6: halt freezes the phase
    assert_halt_phase_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !restart) |=> $stable(s_q.phase));
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] count_inc,
    output logic             step
);
    typedef struct packed {
        logic [CNT_W-1:0] value;
    } cnt_st_t;

    cnt_st_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        count_inc = s_q.value + CNT_W'(1);
        step      = tick && !load;
        if (load)      s_d.value = load_val;
        else if (tick) s_d.value = count_inc;
    end

    assign count = s_q.value;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R4: a write loads the value directly
    assert_load_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (count == $past(load_val)));

    // R2, R5: without a load the counter holds or moves by exactly one (modulo wrap)
    assert_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ((count == $past(count)) || (count == $past(count) + CNT_W'(1))));
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic [CNT_W-1:0] count_inc,
    input  logic             enable,
    input  logic             cmp_we,
    input  logic [CNT_W-1:0] cmp_wdata,
    input  logic             clr,
    output logic             flag,
    output logic [CNT_W-1:0] cmp
);
    typedef struct packed {
        logic [CNT_W-1:0] cmp;
        logic             flag;
    } ch_st_t;

    ch_st_t s_d, s_q;
    logic   hit;

    always_comb begin
        s_d = s_q;
        hit = step && enable && (count_inc == s_q.cmp);
        if (cmp_we) s_d.cmp = cmp_wdata;
        s_d.flag = hit || (s_q.flag && !clr);
    end

    assign flag = s_q.flag;
    assign cmp  = s_q.cmp;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R9: set flag survives until a clear
    assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.flag && !clr) |=> s_q.flag);

    // R8: disabled channel cannot raise its flag
    assert_no_set_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !s_q.flag) |=> !s_q.flag);

    // R7: stepping onto the compare value raises the flag
    assert_flag_on_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (step && enable && (count_inc == s_q.cmp)) |=> s_q.flag);
endmodule

// File: rtl/tmr_compare_unit.sv
module tmr_compare_unit
    import tmr_cmp_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int PRE_W  = 8,
    parameter int NCH    = 4,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              debug_halt,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic [NCH-1:0]    irq
);
    localparam int DIV_MSB = CTRL_DIV_LSB + PRE_W - 1;

    typedef struct packed {
        logic             run;
        logic [PRE_W-1:0] div;
        logic [NCH-1:0]   chen;
    } cfg_st_t;

    cfg_st_t s_d, s_q;

    logic             ctrl_we, count_we, flags_we, chen_we;
    logic             tick, step;
    logic [CNT_W-1:0] count_w, count_inc_w;
    logic [NCH-1:0]   flag_w, clr_w;
    logic [CNT_W-1:0] cmp_w [NCH];

    always_comb begin
        ctrl_we  = bus_we && (bus_addr == ADDR_W'(REG_CTRL));
        count_we = bus_we && (bus_addr == ADDR_W'(REG_COUNT));
        flags_we = bus_we && (bus_addr == ADDR_W'(REG_FLAGS));
        chen_we  = bus_we && (bus_addr == ADDR_W'(REG_CHEN));
        clr_w    = flags_we ? bus_wdata[NCH-1:0] : '0;
    end

    always_comb begin
        s_d = s_q;
        if (ctrl_we) begin
            s_d.run = bus_wdata[CTRL_RUN_BIT];
            s_d.div = bus_wdata[DIV_MSB:CTRL_DIV_LSB];
        end
        if (chen_we) s_d.chen = bus_wdata[NCH-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    tmr_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (s_q.run),
        .halt    (debug_halt),
        .restart (count_we),
        .div     (s_q.div),
        .tick    (tick)
    );

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .load      (count_we),
        .load_val  (bus_wdata),
        .count     (count_w),
        .count_inc (count_inc_w),
        .step      (step)
    );

    for (genvar k = 0; k < NCH; k++) begin : g_ch
        tmr_channel #(.CNT_W(CNT_W)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .step      (step),
            .count_inc (count_inc_w),
            .enable    (s_q.chen[k]),
            .cmp_we    (bus_we && (bus_addr == ADDR_W'(REG_CMP_BASE + k))),
            .cmp_wdata (bus_wdata),
            .clr       (clr_w[k]),
            .flag      (flag_w[k]),
            .cmp       (cmp_w[k])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(REG_CTRL)) begin
            bus_rdata[CTRL_RUN_BIT]         = s_q.run;
            bus_rdata[DIV_MSB:CTRL_DIV_LSB] = s_q.div;
        end else if (bus_addr == ADDR_W'(REG_COUNT)) begin
            bus_rdata = count_w;
        end else if (bus_addr == ADDR_W'(REG_FLAGS)) begin
            bus_rdata[NCH-1:0] = flag_w;
        end else if (bus_addr == ADDR_W'(REG_CHEN)) begin
            bus_rdata[NCH-1:0] = s_q.chen;
        end
        for (int k = 0; k < NCH; k++) begin
            if (bus_addr == ADDR_W'(REG_CMP_BASE + k)) bus_rdata = cmp_w[k];
        end
    end

    assign irq = flag_w;

    // R3: stopped counter holds unless written
    assert_stopped_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.run && !count_we) |=> $stable(count_w));

    // R6: halted counter holds unless written
    assert_halt_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (debug_halt && !count_we) |=> $stable(count_w));
endmodule

// File: tb/sim_tmr_compare_unit.sv
module sim_tmr_compare_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        debug_halt = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  irq;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    tmr_compare_unit u0 (
        .clk(clk), .rst_n(rst_n), .debug_halt(debug_halt), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    typedef struct packed {
        logic [7:0]  n;
        logic [31:0] c;
        logic [15:0] w;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{8'd0,   32'd0,          16'd10},
        '{8'd3,   32'd100,        16'd17},
        '{8'd255, 32'd5,          16'd512},
        '{8'd1,   32'hFFFF_FFFE,  16'd6},
        '{8'd7,   32'd50,         16'd7},
        '{8'd7,   32'd50,         16'd8}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic waitn(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic summary;
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(3'd0, v); chk("R1 ctrl", v, 32'd0);
        rd(3'd1, v); chk("R1 count", v, 32'd0);
        rd(3'd2, v); chk("R1 flags", v, 32'd0);
        rd(3'd4, v); chk("R1 cmp0", v, 32'd0);
        chk("R1 irq", {28'd0, irq}, 32'd0);

        // R2, R4, R5 table
        for (int i = 0; i < 6; i++) begin
            logic [31:0] exp;
            wr(3'd0, {16'd0, VEC[i].n, 8'd1});
            wr(3'd1, VEC[i].c);
            waitn(int'(VEC[i].w));
            exp = VEC[i].c + 32'(int'(VEC[i].w) / (int'(VEC[i].n) + 1));
            rd(3'd1, v);
            chk("R2/R4/R5 count after prescaled run", v, exp);
        end

        // R7 / R8 match on channel 0, channel 1 disabled
        wr(3'd4, 32'd20);
        wr(3'd5, 32'd20);
        wr(3'd3, 32'd1);
        wr(3'd0, 32'd1);
        wr(3'd1, 32'd10);
        waitn(9);
        @(negedge clk); chk("R7 irq one edge early", {28'd0, irq}, 32'd0);
        waitn(1);
        @(negedge clk); chk("R7 R8 irq on match edge", {28'd0, irq}, 32'd1);

        // R9 sticky, zero write, clear
        waitn(5);
        @(negedge clk); chk("R9 sticky", {28'd0, irq}, 32'd1);
        wr(3'd2, 32'd0);
        @(negedge clk); chk("R9 zero write", {28'd0, irq}, 32'd1);
        wr(3'd2, 32'd1);
        @(negedge clk); chk("R9 clear", {28'd0, irq}, 32'd0);
        rd(3'd2, v); chk("R9 flags reg", v, 32'd0);

        // R8 load onto compare value, R3 stopped
        wr(3'd3, 32'hF);
        wr(3'd0, 32'd0);
        wr(3'd6, 32'd500);
        wr(3'd1, 32'd500);
        waitn(4);
        @(negedge clk); chk("R8 load no flag", {28'd0, irq}, 32'd0);
        rd(3'd1, v); chk("R3 stopped count", v, 32'd500);

        // R9 set beats clear on same edge
        wr(3'd2, 32'hF);
        wr(3'd7, 32'd300);
        wr(3'd3, 32'd8);
        wr(3'd0, 32'd1);
        wr(3'd1, 32'd299);
        wr(3'd2, 32'd8);
        @(negedge clk); chk("R9 set wins", {28'd0, irq}, 32'd8);
        wr(3'd2, 32'd8);
        @(negedge clk); chk("R9 later clear", {28'd0, irq}, 32'd0);

        // R6 halt
        @(negedge clk); debug_halt = 1'b1;
        wr(3'd1, 32'd1000);
        waitn(6);
        rd(3'd1, v); chk("R6 halted count", v, 32'd1000);
        @(negedge clk); debug_halt = 1'b0;
        waitn(3);
        rd(3'd1, v); chk("R6 resumed count", v, 32'd1003);

        // R10 readback
        rd(3'd4, v); chk("R10 cmp0", v, 32'd20);
        rd(3'd7, v); chk("R10 cmp3", v, 32'd300);
        rd(3'd3, v); chk("R10 chen", v, 32'd8);
        wr(3'd0, {16'd0, 8'd37, 8'd1});
        rd(3'd0, v); chk("R10 ctrl", v, {16'd0, 8'd37, 8'd1});

        summary();
        $finish;
    end
endmodule